// File: doc/BRIEF.md
# Push-Button Power and Reset Controller

This block is the system-control state machine of a power-management device. One active-low push-button is decoded outside the block into two qualified inputs. A soft press asks for power on or off. A hard press is a manual reset. The block turns the supply rails on when a soft press arrives while the system is off. It then waits for the supply to report power-good. It keeps the rails on only if the host raises its power-enable or power-hold input before the button is let go. If the host does not latch power in time, the block shuts everything down again.

The block also drives the host reset line, which is active low. The line is released only after a programmable number of clock cycles in which power is good and no manual reset is pressed. A manual-reset press pulls the line low at once. A button-status output mirrors the button with no latching. The host can demand a longer press simply by waiting longer before it asserts its hold input. The block has no minimum-hold timer of its own.

Top module: `pb_power_ctrl`

## Requirements
- R1: While `rstN` is low, every `railEn` bit is 0, `sysResetN` is 0 and `pbStatusN` is 1.
- R2: Both button inputs pass through a two-flop synchronizer. `pbStatusN` is 0 exactly while at least one synchronized press is active and 1 otherwise. It changes on the second clock edge after the input changes and never latches.
- R3: From the off state, a synchronized soft press with no hard press turns on all `railEn` bits on the next edge. That is the third edge after `pbEnableN` falls.
- R4: During power-up (rails on, not yet latched by the host), if the button is released while `hostPwrEn` and `hostPwrHold` are both 0, the rails turn off. This happens on the edge after the synchronized release, so a brief unlatched press ends in shutdown.
- R5: `sysResetN` stays 0 until power-good has been seen. It rises exactly TIMEOUT edges after the block enters a powered state (host-latched, or button still held) with `powerGood` high. The count is re-armed whenever that condition is lost.
- R6: If `hostPwrEn` or `hostPwrHold` is high when power-good is reached, or while the button is held, the system stays on after the button is released.
- R7: In the on state, if `hostPwrEn` and `hostPwrHold` are both 0, all `railEn` bits and `sysResetN` go to 0 on the next edge.
- R8: A synchronized hard press drives `sysResetN` to 0 in the same cycle. That is the second edge after `pbResetN` falls. The rails are not affected. `sysResetN` rises TIMEOUT edges after the synchronized release.
- R9: When hard and soft presses are active together, the hard press wins. In the off state such a press does not turn on the rails.
- R10: If `powerGood` falls while on, `sysResetN` goes to 0 on the next edge and the rails stay on. It rises again TIMEOUT edges after the edge that samples `powerGood` high again.
- R11: After a shutdown, the rails stay off until the button is fully released. A press that is still held when shutdown starts cannot restart power.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low block reset |
| pbEnableN | input | 1 | Soft (power request) press, active low, asynchronous |
| pbResetN | input | 1 | Hard (manual reset) press, active low, asynchronous |
| hostPwrEn | input | 1 | Host power-enable latch, synchronous |
| hostPwrHold | input | 1 | Host power-hold latch, synchronous |
| powerGood | input | 1 | Supply power-good indication, synchronous |
| railEn | output | NUM_RAILS | Rail enable outputs, all switched together |
| sysResetN | output | 1 | Active-low host reset |
| pbStatusN | output | 1 | Active-low button status |

## Verification
The embedded properties check, on every cycle, the rules that hold whatever the stimulus is:
- a hard press always holds reset low;
- reset never rises unless the counter has just reached its last value;
- the counter stays within bounds;
- rails only start from a clean soft press;
- a shutdown with the button held is kept until release;
- reset is low whenever the rails are off.

Only the bench scenarios can show the exact cycle counts and event orderings:
- the two-edge synchronizer latency;
- the shutdown after an unlatched brief press;
- the TIMEOUT-edge release after power-good, after a manual reset and after a power-good dropout;
- the hard-over-soft priority while off.

// File: rtl/pb_power_pkg.sv
package pb_power_pkg;

  typedef enum logic [2:0] {
    ST_OFF       = 3'd0,
    ST_SEQ_ON    = 3'd1,
    ST_WAIT_HOST = 3'd2,
    ST_ON        = 3'd3,
    ST_SHUTDOWN  = 3'd4
  } pwrState_t;

  // control -> datapath strobes
  typedef struct packed {
    logic railOn;    // rails powered in this state
    logic tmrClear;  // hold reset timer cleared, reset output low
  } ctlStrobe_t;

  // datapath -> control qualified button presses
  typedef struct packed {
    logic pressEn;
    logic pressRst;
  } btnStatus_t;

endpackage

// File: rtl/pb_sync.sv
module pb_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= {STAGES{RESET_VAL}};
    else       chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];

  initial begin
    assert (STAGES >= 2) else $error("pb_sync needs at least two stages");
  end
endmodule

// File: rtl/pb_power_dp.sv
module pb_power_dp
  import pb_power_pkg::*;
#(
  parameter int TIMEOUT     = 1000,
  parameter int NUM_RAILS   = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 pbEnableN,
  input  logic                 pbResetN,
  input  ctlStrobe_t           ctl,
  output btnStatus_t           btn,
  output logic [NUM_RAILS-1:0] railEn,
  output logic                 sysResetN,
  output logic                 pbStatusN
);
  localparam int NUM_BTN = 2;
  localparam int CW = (TIMEOUT > 1) ? $clog2(TIMEOUT) : 1;
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT - 1);

  // button synchronizers, index 0 = soft press, 1 = hard press
  logic [NUM_BTN-1:0] rawN;
  logic [NUM_BTN-1:0] syncN;
  assign rawN = {pbResetN, pbEnableN};

  for (genvar i = 0; i < NUM_BTN; i++) begin : g_sync
    pb_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
      .clk (clk),
      .rstN(rstN),
      .din (rawN[i]),
      .dout(syncN[i])
    );
  end

  assign btn.pressEn  = ~syncN[0];
  assign btn.pressRst = ~syncN[1];
  assign pbStatusN    = &syncN;

  // reset time-out counter
  logic [CW-1:0] tmrCnt;
  logic          tmrDone;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tmrCnt  <= '0;
      tmrDone <= 1'b0;
    end else if (ctl.tmrClear) begin
      tmrCnt  <= '0;
      tmrDone <= 1'b0;
    end else if (!tmrDone) begin
      if (tmrCnt == LAST) tmrDone <= 1'b1;
      else                tmrCnt  <= tmrCnt + 1'b1;
    end
  end

  assign sysResetN = tmrDone & ~ctl.tmrClear;

  for (genvar r = 0; r < NUM_RAILS; r++) begin : g_rail
    assign railEn[r] = ctl.railOn;
  end

  // R8: a qualified hard press forces reset low in the same cycle
  p_mrst_immediate_r8: assert property (@(posedge clk) disable iff (!rstN)
    btn.pressRst |-> !sysResetN);

  // R5: reset release only follows a completed count
  p_release_after_count_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sysResetN) |-> ($past(tmrCnt) == LAST));

  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rstN)
    tmrCnt <= LAST);

endmodule

// File: rtl/pb_power_ctl.sv
module pb_power_ctl
  import pb_power_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  btnStatus_t btn,
  input  logic       hostPwrEn,
  input  logic       hostPwrHold,
  input  logic       powerGood,
  output ctlStrobe_t ctl
);
  pwrState_t curState, nxtState;
  logic hostKeep, pressAny, enReq;

  assign hostKeep = hostPwrEn | hostPwrHold;
  assign pressAny = btn.pressEn | btn.pressRst;
  assign enReq    = btn.pressEn & ~btn.pressRst;  // hard press has priority

  always_comb begin
    nxtState = curState;
    unique case (curState)
      ST_OFF:
        if (enReq) nxtState = ST_SEQ_ON;
      ST_SEQ_ON:
        if (!hostKeep && !pressAny) nxtState = ST_SHUTDOWN;
        else if (powerGood)         nxtState = hostKeep ? ST_ON : ST_WAIT_HOST;
      ST_WAIT_HOST:
        if (!hostKeep && !pressAny) nxtState = ST_SHUTDOWN;
        else if (!powerGood)        nxtState = ST_SEQ_ON;
        else if (hostKeep)          nxtState = ST_ON;
      ST_ON:
        if (!hostKeep)       nxtState = ST_SHUTDOWN;
        else if (!powerGood) nxtState = ST_SEQ_ON;
      ST_SHUTDOWN:
        if (!pressAny) nxtState = ST_OFF;
      default:
        nxtState = ST_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) curState <= ST_OFF;
    else       curState <= nxtState;
  end

  logic running;
  assign running      = (curState == ST_WAIT_HOST) || (curState == ST_ON);
  assign ctl.railOn   = (curState == ST_SEQ_ON) || running;
  assign ctl.tmrClear = ~running | btn.pressRst;

  // R3: rails only start from a clean soft press
  p_rails_need_press_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ctl.railOn) |-> $past(btn.pressEn && !btn.pressRst));

  // R7: host releasing both latches while on drops the rails next cycle
  p_host_drop_off_r7: assert property (@(posedge clk) disable iff (!rstN)
    (curState == ST_ON && !hostKeep) |=> !ctl.railOn);

  // R11: shutdown persists while the button is still held
  p_shutdown_holds_r11: assert property (@(posedge clk) disable iff (!rstN)
    (curState == ST_SHUTDOWN && pressAny) |=> (curState == ST_SHUTDOWN));

  // R4: release without host latch during power-up ends in shutdown
  p_unlatched_release_r4: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.railOn && curState != ST_ON && !pressAny && !hostKeep) |=> !ctl.railOn);

endmodule

// File: rtl/pb_power_ctrl.sv
module pb_power_ctrl
  import pb_power_pkg::*;
#(
  parameter int TIMEOUT     = 1000,
  parameter int NUM_RAILS   = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 pbEnableN,
  input  logic                 pbResetN,
  input  logic                 hostPwrEn,
  input  logic                 hostPwrHold,
  input  logic                 powerGood,
  output logic [NUM_RAILS-1:0] railEn,
  output logic                 sysResetN,
  output logic                 pbStatusN
);
  ctlStrobe_t ctl;
  btnStatus_t btn;

  pb_power_dp #(
    .TIMEOUT    (TIMEOUT),
    .NUM_RAILS  (NUM_RAILS),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .pbEnableN(pbEnableN),
    .pbResetN (pbResetN),
    .ctl      (ctl),
    .btn      (btn),
    .railEn   (railEn),
    .sysResetN(sysResetN),
    .pbStatusN(pbStatusN)
  );

  pb_power_ctl u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .btn        (btn),
    .hostPwrEn  (hostPwrEn),
    .hostPwrHold(hostPwrHold),
    .powerGood  (powerGood),
    .ctl        (ctl)
  );

  // R7: host reset is low whenever the rails are off
  p_rails_off_reset_low_r7: assert property (@(posedge clk) disable iff (!rstN)
    !railEn[0] |-> !sysResetN);

endmodule

// File: tb/sim_pb_power_ctrl.sv
module sim_pb_power_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int T  = 20;
  localparam int NR = 3;
  localparam int SIG_RAIL = 0;
  localparam int SIG_RST  = 1;
  localparam int SIG_STAT = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pbEnableN = 1'b1;
  logic pbResetN = 1'b1;
  logic hostPwrEn = 1'b0;
  logic hostPwrHold = 1'b0;
  logic powerGood = 1'b0;
  logic [NR-1:0] railEn;
  logic sysResetN;
  logic pbStatusN;

  pb_power_ctrl #(.TIMEOUT(T), .NUM_RAILS(NR), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rstN(rstN), .pbEnableN(pbEnableN), .pbResetN(pbResetN),
    .hostPwrEn(hostPwrEn), .hostPwrHold(hostPwrHold), .powerGood(powerGood),
    .railEn(railEn), .sysResetN(sysResetN), .pbStatusN(pbStatusN)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int    at;
    int    sig;
    logic  val;
    string req;
  } expItem_t;

  expItem_t expQ[$];
  int total = 0;
  int bad = 0;
  bit finished = 0;

  // driver side: schedule an expectation off cycles ahead, kept sorted
  task automatic expectAt(input int off, input int sig, input logic val, input string req);
    expItem_t it;
    int idx;
    it.at = cyc + off; it.sig = sig; it.val = val; it.req = req;
    idx = expQ.size();
    for (int k = 0; k < expQ.size(); k++) begin
      if (expQ[k].at > it.at) begin idx = k; break; end
    end
    expQ.insert(idx, it);
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: pops and compares at the falling edge
  always @(negedge clk) begin
    while (expQ.size() > 0 && expQ[0].at <= cyc) begin
      expItem_t it;
      logic act;
      it = expQ.pop_front();
      case (it.sig)
        SIG_RAIL: act = (railEn == {NR{1'b1}}) ? 1'b1 : ((railEn == '0) ? 1'b0 : 1'bx);
        SIG_RST:  act = sysResetN;
        default:  act = pbStatusN;
      endcase
      total++;
      if (act !== it.val) begin
        bad++;
        $display("FAIL %s sig=%0d cycle=%0d actual=%b expected=%b",
                 it.req, it.sig, cyc, act, it.val);
      end
    end
  end

  initial begin
    waitCyc(3);
    // R1 reset state
    expectAt(1, SIG_RAIL, 1'b0, "R1");
    expectAt(1, SIG_RST,  1'b0, "R1");
    expectAt(1, SIG_STAT, 1'b1, "R1");
    waitCyc(2);
    rstN = 1'b1;
    waitCyc(3);

    // brief unlatched press -> shutdown (R2, R3, R4)
    pbEnableN = 1'b0;
    expectAt(1, SIG_STAT, 1'b1, "R2");
    expectAt(2, SIG_STAT, 1'b0, "R2");
    expectAt(2, SIG_RAIL, 1'b0, "R3");
    expectAt(3, SIG_RAIL, 1'b1, "R3");
    waitCyc(5);
    pbEnableN = 1'b1;
    expectAt(2, SIG_STAT, 1'b1, "R2");
    expectAt(2, SIG_RAIL, 1'b1, "R4");
    expectAt(3, SIG_RAIL, 1'b0, "R4");
    expectAt(3, SIG_RST,  1'b0, "R4");
    expectAt(6, SIG_RAIL, 1'b0, "R4");
    waitCyc(8);

    // press, host latched at power-good (R5, R6)
    pbEnableN = 1'b0;
    expectAt(3, SIG_RAIL, 1'b1, "R3");
    expectAt(4, SIG_RST,  1'b0, "R5");
    waitCyc(5);
    powerGood = 1'b1; hostPwrEn = 1'b1;
    expectAt(T,     SIG_RST, 1'b0, "R5");
    expectAt(T + 1, SIG_RST, 1'b1, "R5");
    waitCyc(T + 4);
    pbEnableN = 1'b1;
    expectAt(2, SIG_STAT, 1'b1, "R2");
    expectAt(4, SIG_RAIL, 1'b1, "R6");
    expectAt(4, SIG_RST,  1'b1, "R6");
    waitCyc(6);

    // manual reset while on (R8)
    pbResetN = 1'b0;
    expectAt(1, SIG_RST,  1'b1, "R8");
    expectAt(2, SIG_RST,  1'b0, "R8");
    expectAt(2, SIG_STAT, 1'b0, "R2");
    expectAt(3, SIG_RAIL, 1'b1, "R8");
    waitCyc(6);
    pbResetN = 1'b1;
    expectAt(T + 1, SIG_RST,  1'b0, "R8");
    expectAt(T + 2, SIG_RST,  1'b1, "R8");
    expectAt(T + 2, SIG_RAIL, 1'b1, "R8");
    waitCyc(T + 5);

    // power-good dropout while on (R10)
    powerGood = 1'b0;
    expectAt(1, SIG_RST,  1'b0, "R10");
    expectAt(1, SIG_RAIL, 1'b1, "R10");
    waitCyc(4);
    powerGood = 1'b1;
    expectAt(T,     SIG_RST, 1'b0, "R10");
    expectAt(T + 1, SIG_RST, 1'b1, "R10");
    waitCyc(T + 4);

    // host drops with button held: shutdown waits for release (R7, R11)
    pbEnableN = 1'b0;
    waitCyc(4);
    hostPwrEn = 1'b0;
    expectAt(1, SIG_RAIL, 1'b0, "R7");
    expectAt(1, SIG_RST,  1'b0, "R7");
    waitCyc(1);
    powerGood = 1'b0;
    expectAt(3, SIG_RAIL, 1'b0, "R11");
    expectAt(5, SIG_RAIL, 1'b0, "R11");
    waitCyc(6);
    pbEnableN = 1'b1;
    expectAt(4, SIG_RAIL, 1'b0, "R11");
    expectAt(8, SIG_RAIL, 1'b0, "R11");
    waitCyc(10);

    // both presses while off: hard press wins (R9)
    pbEnableN = 1'b0; pbResetN = 1'b0;
    expectAt(2, SIG_STAT, 1'b0, "R9");
    expectAt(4, SIG_RAIL, 1'b0, "R9");
    expectAt(6, SIG_RAIL, 1'b0, "R9");
    waitCyc(7);
    pbEnableN = 1'b1; pbResetN = 1'b1;
    waitCyc(5);

    // power-good before host latch, button held (R5, R6)
    pbEnableN = 1'b0;
    waitCyc(4);
    powerGood = 1'b1;
    expectAt(T,     SIG_RST, 1'b0, "R5");
    expectAt(T + 1, SIG_RST, 1'b1, "R5");
    waitCyc(T + 3);
    hostPwrHold = 1'b1;
    waitCyc(2);
    pbEnableN = 1'b1;
    expectAt(5, SIG_RAIL, 1'b1, "R6");
    expectAt(5, SIG_RST,  1'b1, "R6");
    waitCyc(6);

    // plain host drop, button free (R7)
    hostPwrHold = 1'b0;
    expectAt(1, SIG_RAIL, 1'b0, "R7");
    expectAt(1, SIG_RST,  1'b0, "R7");
    expectAt(3, SIG_RAIL, 1'b0, "R7");
    waitCyc(2);
    powerGood = 1'b0;
    waitCyc(4);

    while (expQ.size() > 0) waitCyc(1);
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule